// File: doc/BRIEF.md
# Priority-Based Shared Bus Arbiter

The block decides which of six on-chip masters owns a shared bus for its next address cycle. Each master raises a request. The arbiter builds a 2-bit priority for each requester from a small set of configuration registers and a few live side inputs. The highest priority wins. When several requesters share that priority, a tie-break mode decides: either a programmable fixed ranking or a rotating order.

Once a master is granted, the arbiter runs the address handshake. In the cycle it grants, it captures the winner's address and read/write qualifier. From the next cycle it presents them to the slaves and holds the grant until a slave acknowledges. If no slave answers within a bounded window, the arbiter ends the cycle itself and flags an error to the owner. The request phase is the idle cycle in which arbitration happens, so consecutive address cycles are separated by at least one such cycle.

Master IDs are fixed:
- 0: instruction fetch
- 1: data cache
- 2: external master
- 3: PCI bridge
- 4: memory access layer
- 5: DMA

Top module: `prio_bus_arbiter`

## Requirements
- R1: Among the requesting masters, the one with the numerically largest 2-bit priority is granted (2'b11 highest, 2'b00 lowest).
- R2: After reset, the configuration is as follows. The instruction-fetch, memory-access-layer, external low and high, and all four DMA channel priorities are 2'b10. The PCI bridge priority is 2'b11. The data-cache programmable bit is 0.
- R3: Master 1's priority is {dcu_hi_pri_i, stored bit}. A write with cfg_sel_i=1 stores only cfg_wdata_i[0].
- R4: Master 2 has two priority fields, set by a write with cfg_sel_i=2. The low field is cfg_wdata_i[1:0] and the high field is cfg_wdata_i[3:2]. Master 2 uses the high field while ext_hold_pri_i=1 and the low field otherwise.
- R5: A write with cfg_sel_i=5 sets the DMA channel priorities, channel c taking cfg_wdata_i[2c+1:2c]. Master 5 requests with the priority of the channel selected by dma_chan_i.
- R6: A write with cfg_sel_i=6 sets the control register. Bit 0 is the mode (0 fixed, 1 rotating). Bits [3k+3:3k+1] hold the master ID at rank k, where rank 0 is preferred. In fixed mode the equal-priority requester with the best rank wins. The control register resets to fixed mode with rank k holding ID k.
- R7: In rotating mode, among equal-priority requesters the first ID after the last granted master, in cyclic order, wins. The last granted master starts as ID 5 after reset.
- R8: A grant begins the cycle after a request phase that has a requester. While granted, gnt_o stays one-hot and unchanged and no arbitration happens. s_valid_o, s_mid_o, s_addr_o and s_rnw_o show the owner and its address and qualifier captured at grant; they are zero when idle.
- R9: s_ack_i during a transfer ends the cycle, pulses addr_ack_o for the owner in that same cycle, and returns the arbiter to the request phase.
- R10: If no acknowledge arrives in 16 transfer cycles, timeout_err_o pulses for the owner in the 16th cycle and the cycle ends. An acknowledge in that cycle wins over the timeout.
- R11: During and right after reset, no grant, acknowledge, error or slave valid is driven.
- R12: Writes with cfg_sel_i=0, 3 and 4 set cfg_wdata_i[1:0] as the priority of masters 0, 3 and 4 respectively. A configuration write takes effect for arbitration from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Bus request per master |
| rnw_i | input | 6 | Read/write qualifier per master |
| addr_i | input | 6*AW | Address per master, master i at [i*AW +: AW] |
| dcu_hi_pri_i | input | 1 | Hardware-driven upper priority bit of master 1 |
| ext_hold_pri_i | input | 1 | Selects master 2's high priority field |
| dma_chan_i | input | 2 | Active DMA channel |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| gnt_o | output | 6 | One-hot grant, held through the transfer phase |
| addr_ack_o | output | 6 | Address acknowledge to the owner |
| timeout_err_o | output | 6 | Timeout error to the owner |
| s_valid_o | output | 1 | Address valid to slaves |
| s_addr_o | output | AW | Owner's captured address |
| s_rnw_o | output | 1 | Owner's captured qualifier |
| s_mid_o | output | 3 | Owner ID |
| s_ack_i | input | 1 | Slave address acknowledge |

## Verification
Each request pattern is tried against a behavioural reference model that is compared with every output on every clock. The patterns are as follows:
- Mixed priorities separate the winner by level alone.
- All-equal patterns expose the tie-break, first under reset ranking, then under a reversed ranking, then in rotating mode over many consecutive grants.
- Toggling the data-cache hardware bit, the hold-priority input and the DMA channel select shows that each special priority source is followed live.
- A masked write shows that only the data cache's low bit is stored.
- Varied acknowledge delays, including none at all, separate the hold-until-acknowledge behaviour from the timeout path.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_MST = 6;
  localparam int MID_W   = $clog2(NUM_MST);
  localparam int PRIO_W  = 2;
  localparam int DMA_CH  = 4;
  localparam int CH_W    = $clog2(DMA_CH);
  localparam int CFG_DW  = 32;
  localparam int SEL_W   = 3;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [MID_W-1:0]  mid_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_IFETCH = 3'd0,
    SEL_DCACHE = 3'd1,
    SEL_EXT    = 3'd2,
    SEL_PCI    = 3'd3,
    SEL_MAL    = 3'd4,
    SEL_DMA    = 3'd5,
    SEL_CTRL   = 3'd6
  } cfg_sel_e;

  typedef enum logic {TIE_FIXED = 1'b0, TIE_RR = 1'b1} tie_mode_e;
  typedef enum logic {PH_REQ = 1'b0, PH_XFER = 1'b1} phase_e;

  localparam prio_t PRIO_DEF = 2'b10;
  localparam prio_t PRIO_TOP = 2'b11;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import arb_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [CFG_DW-1:0]             wdata_i,
  input  logic                          dcu_hi_pri_i,
  input  logic                          ext_hold_pri_i,
  input  logic [CH_W-1:0]               dma_chan_i,
  output logic [NUM_MST-1:0][PRIO_W-1:0] prio_o,
  output tie_mode_e                     mode_o,
  output logic [NUM_MST-1:0][MID_W-1:0] rank_o
);
  prio_t                         ifetch_q, ext_lo_q, ext_hi_q, pci_q, mal_q;
  logic                          dc_lo_q;
  logic [DMA_CH-1:0][PRIO_W-1:0] dma_q;
  tie_mode_e                     mode_q;
  logic [NUM_MST-1:0][MID_W-1:0] rank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifetch_q <= PRIO_DEF;
      dc_lo_q  <= 1'b0;
      ext_lo_q <= PRIO_DEF;
      ext_hi_q <= PRIO_DEF;
      pci_q    <= PRIO_TOP;
      mal_q    <= PRIO_DEF;
      mode_q   <= TIE_FIXED;
      for (int c = 0; c < DMA_CH; c++) dma_q[c] <= PRIO_DEF;
      for (int k = 0; k < NUM_MST; k++) rank_q[k] <= mid_t'(k);
    end else if (we_i) begin
      unique case (sel_i)
        SEL_IFETCH: ifetch_q <= wdata_i[PRIO_W-1:0];
        SEL_DCACHE: dc_lo_q  <= wdata_i[0];  // upper bit is hardware-owned
        SEL_EXT: begin
          ext_lo_q <= wdata_i[PRIO_W-1:0];
          ext_hi_q <= wdata_i[2*PRIO_W-1:PRIO_W];
        end
        SEL_PCI:    pci_q <= wdata_i[PRIO_W-1:0];
        SEL_MAL:    mal_q <= wdata_i[PRIO_W-1:0];
        SEL_DMA:
          for (int c = 0; c < DMA_CH; c++) dma_q[c] <= wdata_i[c*PRIO_W +: PRIO_W];
        SEL_CTRL: begin
          mode_q <= tie_mode_e'(wdata_i[0]);
          for (int k = 0; k < NUM_MST; k++) rank_q[k] <= wdata_i[1+k*MID_W +: MID_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    prio_o[0] = ifetch_q;
    prio_o[1] = {dcu_hi_pri_i, dc_lo_q};
    prio_o[2] = ext_hold_pri_i ? ext_hi_q : ext_lo_q;
    prio_o[3] = pci_q;
    prio_o[4] = mal_q;
    prio_o[5] = dma_q[dma_chan_i];
  end

  assign mode_o = mode_q;
  assign rank_o = rank_q;
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
(
  input  logic [NUM_MST-1:0]             req_i,
  input  logic [NUM_MST-1:0][PRIO_W-1:0] prio_i,
  input  tie_mode_e                      mode_i,
  input  logic [NUM_MST-1:0][MID_W-1:0]  rank_i,
  input  mid_t                           last_i,
  output logic                           any_o,
  output mid_t                           win_o
);
  prio_t              top;
  logic [NUM_MST-1:0] tie;
  logic               fx_found, rr_found;
  mid_t               fx_win, rr_win;
  int                 idx;

  always_comb begin
    top = '0;
    for (int i = 0; i < NUM_MST; i++)
      if (req_i[i] && prio_i[i] > top) top = prio_i[i];
    for (int i = 0; i < NUM_MST; i++)
      tie[i] = req_i[i] && (prio_i[i] == top);

    fx_found = 1'b0;
    fx_win   = '0;
    for (int k = 0; k < NUM_MST; k++)
      if (!fx_found && int'(rank_i[k]) < NUM_MST && tie[rank_i[k]]) begin
        fx_found = 1'b1;
        fx_win   = rank_i[k];
      end

    rr_found = 1'b0;
    rr_win   = '0;
    idx      = 0;
    for (int off = 1; off <= NUM_MST; off++) begin
      idx = (int'(last_i) + off) % NUM_MST;
      if (!rr_found && tie[idx[MID_W-1:0]]) begin
        rr_found = 1'b1;
        rr_win   = idx[MID_W-1:0];
      end
    end

    win_o = (mode_i == TIE_RR) ? rr_win : fx_win;
  end

  assign any_o = |req_i;
endmodule

// File: rtl/arb_addr_fsm.sv
module arb_addr_fsm
  import arb_pkg::*;
#(
  parameter int AW      = 16,
  parameter int TIMEOUT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               any_req_i,
  input  mid_t               win_i,
  input  logic [AW-1:0]      win_addr_i,
  input  logic               win_rnw_i,
  input  logic               s_ack_i,
  output mid_t               last_o,
  output logic [NUM_MST-1:0] gnt_o,
  output logic [NUM_MST-1:0] addr_ack_o,
  output logic [NUM_MST-1:0] err_o,
  output logic               s_valid_o,
  output logic [AW-1:0]      s_addr_o,
  output logic               s_rnw_o,
  output mid_t               s_mid_o
);
  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  phase_e           phase_q;
  mid_t             owner_q, last_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    addr_q;
  logic             rnw_q;
  logic             xfer, expire;

  assign xfer   = (phase_q == PH_XFER);
  assign expire = xfer && !s_ack_i && (cnt_q == CNT_LAST);  // ack beats timeout

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_REQ;
      owner_q <= '0;
      last_q  <= mid_t'(NUM_MST - 1);
      cnt_q   <= '0;
      addr_q  <= '0;
      rnw_q   <= 1'b0;
    end else if (!xfer) begin
      if (any_req_i) begin
        phase_q <= PH_XFER;
        owner_q <= win_i;
        last_q  <= win_i;
        addr_q  <= win_addr_i;
        rnw_q   <= win_rnw_i;
        cnt_q   <= '0;
      end
    end else if (s_ack_i || expire) begin
      phase_q <= PH_REQ;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    gnt_o = '0;
    if (xfer) gnt_o[owner_q] = 1'b1;
  end

  assign addr_ack_o = s_ack_i ? gnt_o : '0;
  assign err_o      = expire ? gnt_o : '0;
  assign s_valid_o  = xfer;
  assign s_addr_o   = xfer ? addr_q : '0;
  assign s_rnw_o    = xfer && rnw_q;
  assign s_mid_o    = xfer ? owner_q : '0;
  assign last_o     = last_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R8
  AST_GNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o && !s_ack_i && !(|err_o)) |=> ($stable(gnt_o) && $stable(s_addr_o))); // R8
  AST_END_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|addr_ack_o || |err_o) |=> (gnt_o == '0)); // R9
  AST_ACK_TO_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |addr_ack_o |-> (addr_ack_o == gnt_o)); // R9
  AST_ERR_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |err_o |-> (s_valid_o && !s_ack_i)); // R10
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int AW      = 16,
  parameter int TIMEOUT = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_MST-1:0]    req_i,
  input  logic [NUM_MST-1:0]    rnw_i,
  input  logic [NUM_MST*AW-1:0] addr_i,
  input  logic                  dcu_hi_pri_i,
  input  logic                  ext_hold_pri_i,
  input  logic [CH_W-1:0]       dma_chan_i,
  input  logic                  cfg_we_i,
  input  logic [SEL_W-1:0]      cfg_sel_i,
  input  logic [CFG_DW-1:0]     cfg_wdata_i,
  output logic [NUM_MST-1:0]    gnt_o,
  output logic [NUM_MST-1:0]    addr_ack_o,
  output logic [NUM_MST-1:0]    timeout_err_o,
  output logic                  s_valid_o,
  output logic [AW-1:0]         s_addr_o,
  output logic                  s_rnw_o,
  output logic [MID_W-1:0]      s_mid_o,
  input  logic                  s_ack_i
);
  logic [NUM_MST-1:0][PRIO_W-1:0] prio;
  logic [NUM_MST-1:0][MID_W-1:0]  rank;
  tie_mode_e                      mode;
  mid_t                           last, win;
  logic                           any_req;
  logic [AW-1:0]                  win_addr;

  arb_cfg_regs i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .dcu_hi_pri_i, .ext_hold_pri_i, .dma_chan_i,
    .prio_o(prio), .mode_o(mode), .rank_o(rank)
  );

  arb_pick i_pick (
    .req_i, .prio_i(prio), .mode_i(mode), .rank_i(rank),
    .last_i(last), .any_o(any_req), .win_o(win)
  );

  assign win_addr = addr_i[int'(win)*AW +: AW];

  arb_addr_fsm #(.AW(AW), .TIMEOUT(TIMEOUT)) i_fsm (
    .clk_i, .rst_ni,
    .any_req_i(any_req), .win_i(win),
    .win_addr_i(win_addr), .win_rnw_i(rnw_i[win]),
    .s_ack_i, .last_o(last),
    .gnt_o, .addr_ack_o, .err_o(timeout_err_o),
    .s_valid_o, .s_addr_o, .s_rnw_o, .s_mid_o
  );

  AST_REQ_GETS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_valid_o && |req_i) |=> |gnt_o); // R1
  AST_GNT_WAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(s_valid_o) |-> |($past(req_i) & gnt_o)); // R8
endmodule

// File: tb/test_prio_bus_arbiter.sv
`timescale 1ns/1ps
module test_prio_bus_arbiter;
  localparam int AW = 16;
  localparam int NM = 6;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NM-1:0] req_i = '0, rnw_i = '0;
  logic [NM*AW-1:0] addr_i = '0;
  logic dcu_hi = 1'b0, hold = 1'b0;
  logic [1:0] chan = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic s_ack = 1'b0;
  logic [NM-1:0] gnt, aack, terr;
  logic s_valid, s_rnw;
  logic [AW-1:0] s_addr;
  logic [2:0] s_mid;

  always #2.5 clk = ~clk;

  prio_bus_arbiter #(.AW(AW), .TIMEOUT(TO)) i_prio_bus_arbiter (
    .clk_i(clk), .rst_ni, .req_i, .rnw_i, .addr_i,
    .dcu_hi_pri_i(dcu_hi), .ext_hold_pri_i(hold), .dma_chan_i(chan),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .gnt_o(gnt), .addr_ack_o(aack), .timeout_err_o(terr),
    .s_valid_o(s_valid), .s_addr_o(s_addr), .s_rnw_o(s_rnw), .s_mid_o(s_mid),
    .s_ack_i(s_ack)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R11";

  // reference model state
  int m_ifetch, m_dclo, m_extlo, m_exthi, m_pci, m_mal, m_mode;
  int m_dma[4];
  int m_rank[6];
  bit m_xfer;
  int m_own, m_cnt, m_last, m_addr, m_rnw;

  task automatic m_reset();
    m_ifetch = 2; m_dclo = 0; m_extlo = 2; m_exthi = 2; m_pci = 3; m_mal = 2; m_mode = 0;
    for (int c = 0; c < 4; c++) m_dma[c] = 2;
    for (int k = 0; k < 6; k++) m_rank[k] = k;
    m_xfer = 0; m_own = 0; m_cnt = 0; m_last = 5; m_addr = 0; m_rnw = 0;
  endtask

  function automatic int m_prio(int i);
    case (i)
      0: return m_ifetch;
      1: return int'(dcu_hi) * 2 + m_dclo;
      2: return hold ? m_exthi : m_extlo;
      3: return m_pci;
      4: return m_mal;
      default: return m_dma[chan];
    endcase
  endfunction

  function automatic int m_pick();
    int top = -1;
    for (int i = 0; i < NM; i++) if (req_i[i] && m_prio(i) > top) top = m_prio(i);
    if (m_mode == 0) begin
      for (int k = 0; k < NM; k++) begin
        int r = m_rank[k];
        if (r < NM && req_i[r] && m_prio(r) == top) return r;
      end
    end else begin
      for (int off = 1; off <= NM; off++) begin
        int r = (m_last + off) % NM;
        if (req_i[r] && m_prio(r) == top) return r;
      end
    end
    return 0;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    logic [NM-1:0] eg;
    bit to;
    eg = m_xfer ? NM'(1 << m_own) : '0;
    to = m_xfer && !s_ack && m_cnt == TO - 1;
    chk("gnt_o", 32'(gnt), 32'(eg));
    chk("addr_ack_o", 32'(aack), (m_xfer && s_ack) ? 32'(eg) : 0);
    chk("timeout_err_o", 32'(terr), to ? 32'(eg) : 0);
    chk("s_valid_o", 32'(s_valid), 32'(m_xfer));
    chk("s_addr_o", 32'(s_addr), m_xfer ? m_addr : 0);
    chk("s_rnw_o", 32'(s_rnw), m_xfer ? m_rnw : 0);
    chk("s_mid_o", 32'(s_mid), m_xfer ? m_own : 0);
  endtask

  task automatic m_step();
    if (!rst_ni) begin m_reset(); return; end
    if (!m_xfer) begin
      if (req_i != 0) begin
        m_own = m_pick(); m_last = m_own;
        m_addr = int'(addr_i[m_own*AW +: AW]); m_rnw = int'(rnw_i[m_own]);
        m_cnt = 0; m_xfer = 1;
      end
    end else if (s_ack || m_cnt == TO - 1) m_xfer = 0;
    else m_cnt++;
    if (cfg_we) begin
      case (cfg_sel)
        0: m_ifetch = int'(cfg_wdata[1:0]);
        1: m_dclo = int'(cfg_wdata[0]);
        2: begin m_extlo = int'(cfg_wdata[1:0]); m_exthi = int'(cfg_wdata[3:2]); end
        3: m_pci = int'(cfg_wdata[1:0]);
        4: m_mal = int'(cfg_wdata[1:0]);
        5: for (int c = 0; c < 4; c++) m_dma[c] = int'(cfg_wdata[2*c +: 2]);
        6: begin
          m_mode = int'(cfg_wdata[0]);
          for (int k = 0; k < 6; k++) m_rank[k] = int'(cfg_wdata[1+3*k +: 3]);
        end
        default: ;
      endcase
    end
  endtask

  // caller sets inputs just after a negedge
  task automatic tick();
    for (int i = 0; i < NM; i++) addr_i[i*AW +: AW] = AW'(i * 16'h1111 + cyc * 7);
    rnw_i = NM'(cyc) ^ 6'h15;
    #1 compare();
    @(posedge clk) m_step();
    @(negedge clk) cyc++;
  endtask

  task automatic wr(int sel, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  // request phase, dly cycles without ack, then ack (or no ack at all)
  task automatic xact(logic [NM-1:0] r, int dly, bit no_ack = 0);
    req_i = r; s_ack = 0;
    tick();
    req_i = '0;
    for (int i = 0; i < dly; i++) tick();
    if (!no_ack) begin s_ack = 1; tick(); s_ack = 0; end
  endtask

  function automatic logic [31:0] ctrl(int mode, int r0, int r1, int r2, int r3, int r4, int r5);
    int r[6] = '{r0, r1, r2, r3, r4, r5};
    logic [31:0] d = 32'(mode & 1);
    for (int k = 0; k < 6; k++) d[1+3*k +: 3] = 3'(r[k]);
    return d;
  endfunction

  initial begin
    m_reset();
    @(negedge clk);
    cur_req = "R11";
    for (int i = 0; i < 3; i++) tick();
    rst_ni = 1'b1;
    tick(); tick();

    cur_req = "R2";   // PCI resets highest; others tie at 2'b10
    xact(6'h3F, 1);
    xact(6'h37, 0);
    xact(6'h34, 2);

    cur_req = "R12";
    wr(0, 32'h1); wr(4, 32'h3); wr(3, 32'h2);
    cur_req = "R1";
    xact(6'h11, 1);
    xact(6'h19, 0);
    xact(6'h01, 3);

    cur_req = "R3";
    wr(1, 32'h1); dcu_hi = 1;
    xact(6'h1A, 0);
    dcu_hi = 0;
    xact(6'h03, 1);
    wr(1, 32'h2);        // bit 1 must not stick
    dcu_hi = 0;
    xact(6'h03, 0);
    dcu_hi = 1;
    xact(6'h13, 0);

    cur_req = "R4";
    wr(2, 32'hC);
    hold = 0; xact(6'h05, 0);
    hold = 1; xact(6'h05, 1);
    hold = 0; xact(6'h04, 0);

    cur_req = "R5";
    wr(5, 32'hE4);
    chan = 0; xact(6'h21, 0);
    chan = 2; xact(6'h21, 0);
    chan = 3; xact(6'h31, 1);
    chan = 1; xact(6'h21, 0);

    cur_req = "R6";
    wr(6, ctrl(0, 5, 4, 3, 2, 1, 0));
    xact(6'h21, 0);
    xact(6'h31, 0);
    wr(6, ctrl(0, 2, 0, 5, 1, 3, 4));
    dcu_hi = 1; hold = 0; wr(2, 32'hA); chan = 2;
    xact(6'h3F, 0);
    xact(6'h3B, 0);

    cur_req = "R7";
    wr(0, 32'h2); wr(1, 32'h0); wr(3, 32'h2); wr(4, 32'h2); wr(5, 32'hAA);
    wr(6, ctrl(1, 0, 1, 2, 3, 4, 5));
    for (int i = 0; i < 8; i++) xact(6'h3F, i % 3);
    xact(6'h15, 0); xact(6'h15, 0); xact(6'h15, 0);
    xact(6'h2A, 0); xact(6'h09, 0);

    cur_req = "R8";
    req_i = 6'h02; tick();
    req_i = 6'h3F; for (int i = 0; i < 6; i++) tick();
    s_ack = 1; tick(); s_ack = 0;
    for (int i = 0; i < 3; i++) tick();
    req_i = '0; tick();

    cur_req = "R9";
    xact(6'h08, 0); xact(6'h20, 4);

    cur_req = "R10";
    xact(6'h10, 18, 1);
    tick();
    xact(6'h04, 15);      // ack in the last allowed cycle
    xact(6'h01, 16, 1);

    tick(); tick();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule